// File: doc/BRIEF.md
# Rate-Bridging Link Transmit Framer

This block carries a steady stream of parallel trigger words, produced on a fixed system clock of about 80 MHz, onto the parallel side of a serial transceiver. The transceiver runs from its own oscillator at a faster link rate near 150 MHz, and the two clocks have no phase relation. Words enter a small dual-port buffer in the system domain. Gray-coded pointers pass between the domains through two-flop synchronizers, and whole words leave the buffer in the link domain.

The link side groups the stream into frames that each span one 25 ns bunch crossing. A frame holds two data words and then a CRC-16 check word. The link has more cycles than the payload needs. A spare cycle between frames carries a comma K-character. A spare cycle inside a frame, while the second word has not yet crossed, carries a padding word. Both kinds of idle word are sent with the data-enable flag low, so the receiver can drop them.

The system side keeps a sticky overflow flag. The flag is set if a word arrives while the buffer is full, and a reset clears it.

Top module: `lt_link_tx_framer`

## Requirements
- R1: While reset is asserted and after it is released, before any word crosses, the link outputs show enable 0, K flag 1 and the comma word 16'h50BC, and the overflow flag is 0.
- R2: The link words sent with enable 1 repeat the pattern of first input word, second input word, check word. Every accepted input word appears exactly once, in input order, with none added or lost.
- R3: The check word is the CRC-16 of the frame's two data words. It uses polynomial 0x1021, seed 0xFFFF, MSB-first bit order, no reflection and no final XOR.
- R4: The check word appears on the link in the cycle right after the frame's second data word. No idle word separates them.
- R5: An idle link cycle at a frame boundary carries enable 0, K flag 1 and the comma word 16'h50BC.
- R6: An idle link cycle after a frame's first word, while the block waits for the second word, carries enable 0, K flag 0 and the padding word 16'h0000.
- R7: Every link word sent with enable 1 has the K flag at 0.
- R8: A write offered while the buffer holds its full depth of words is dropped and sets the overflow flag. The flag stays at 1 until reset, including after the link drains the buffer. While the link keeps pace, the flag stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System word clock, about 80 MHz |
| link_clk | input | 1 | Transceiver parallel clock, faster and unrelated |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| sys_valid | input | 1 | Input word valid in this system cycle |
| sys_data | input | DATA_W | Input trigger word |
| sys_overflow | output | 1 | Sticky flag: an input word was dropped because the buffer was full |
| link_data | output | DATA_W | Word to the transceiver |
| link_k | output | 1 | Marks link_data as a K-character |
| link_en | output | 1 | Marks link_data as payload: a data word or a check word |

## Verification
A read pointer that runs ahead of the synchronized write pointer, or a frame phase that slips, shows at the link outputs within one or two link cycles. It appears as a wrong, repeated or missing enabled word, or as a check word that does not match. A wrong CRC register shows on the third enabled word of the frame. A broken idle selection shows as a comma inside a frame, or a pad between frames, at the next idle cycle. A pointer comparison in the system domain that is wrong shows only when the link clock is stalled and the buffer fills. The bench stalls the link clock on purpose so that this can be observed on the overflow flag.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic [1:0] {
    PH_HEAD  = 2'd0,
    PH_TAIL  = 2'd1,
    PH_CHECK = 2'd2
  } frame_phase_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

endpackage

// File: rtl/lt_sync.sv
module lt_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end

endmodule

// File: rtl/lt_rst_sync.sv
module lt_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;

endmodule

// File: rtl/lt_dpram.sv
module lt_dpram #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/lt_bridge_wr.sv
module lt_bridge_wr #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [DW-1:0] data,
  input  logic [AW:0]   rd_gray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic [AW:0]   wr_gray,
  output logic          overflow
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_MASK = {2'b11, {(AW-1){1'b0}}};

  logic [PW-1:0] bin_q, bin_d;
  logic [PW-1:0] gray_q, gray_d;
  logic          ovf_q, ovf_d;
  logic          full;
  logic          accept;

  assign full   = ((gray_q ^ rd_gray_s) == FULL_MASK);
  assign accept = valid && !full;

  always_comb begin
    bin_d  = bin_q;
    ovf_d  = ovf_q;
    if (accept) begin
      bin_d = bin_q + PW'(1);
    end
    if (valid && full) begin
      ovf_d = 1'b1;
    end
    gray_d = (bin_d >> 1) ^ bin_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      ovf_q  <= ovf_d;
    end
  end

  assign we       = accept;
  assign waddr    = bin_q[AW-1:0];
  assign wdata    = data;
  assign wr_gray  = gray_q;
  assign overflow = ovf_q;

  // R8: once set, the overflow flag holds until reset
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R8: the published pointer moves by at most one Gray step per cycle
  a_r8_gray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/lt_framer.sv
module lt_framer
  import lt_pkg::*;
#(
  parameter int            DW    = 16,
  parameter int            AW    = 3,
  parameter logic [DW-1:0] COMMA = 16'h50BC,
  parameter logic [DW-1:0] PAD   = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   wr_gray_s,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rd_gray,
  output logic [DW-1:0] link_data,
  output logic          link_k,
  output logic          link_en
);

  localparam int PW = AW + 1;

  function automatic logic [15:0] crc_fold(input logic [15:0] seed,
                                           input logic [DW-1:0] word);
    logic [15:0] c;
    logic        fb;
    c = seed;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = c[15] ^ word[i];
      c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return c;
  endfunction

  frame_phase_e  phase_q, phase_d;
  logic [15:0]   crc_q, crc_d;
  logic [PW-1:0] rd_bin_q, rd_bin_d;
  logic [PW-1:0] rd_gray_q, rd_gray_d;
  logic [DW-1:0] data_q, data_d;
  logic          k_q, k_d;
  logic          en_q, en_d;
  logic          empty;

  assign empty = (rd_gray_q == wr_gray_s);

  always_comb begin
    phase_d  = phase_q;
    crc_d    = crc_q;
    rd_bin_d = rd_bin_q;
    data_d   = COMMA;
    k_d      = 1'b1;
    en_d     = 1'b0;
    unique case (phase_q)
      PH_HEAD: begin
        if (!empty) begin
          data_d   = rdata;
          k_d      = 1'b0;
          en_d     = 1'b1;
          crc_d    = crc_fold(CRC_SEED, rdata);
          rd_bin_d = rd_bin_q + PW'(1);
          phase_d  = PH_TAIL;
        end
      end
      PH_TAIL: begin
        k_d    = 1'b0;
        data_d = PAD;
        if (!empty) begin
          data_d   = rdata;
          en_d     = 1'b1;
          crc_d    = crc_fold(crc_q, rdata);
          rd_bin_d = rd_bin_q + PW'(1);
          phase_d  = PH_CHECK;
        end
      end
      PH_CHECK: begin
        data_d  = DW'(crc_q);
        k_d     = 1'b0;
        en_d    = 1'b1;
        phase_d = PH_HEAD;
      end
      default: phase_d = PH_HEAD;
    endcase
    rd_gray_d = (rd_bin_d >> 1) ^ rd_bin_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_HEAD;
      crc_q     <= CRC_SEED;
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
      data_q    <= COMMA;
      k_q       <= 1'b1;
      en_q      <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      crc_q     <= crc_d;
      rd_bin_q  <= rd_bin_d;
      rd_gray_q <= rd_gray_d;
      data_q    <= data_d;
      k_q       <= k_d;
      en_q      <= en_d;
    end
  end

  assign raddr     = rd_bin_q[AW-1:0];
  assign rd_gray   = rd_gray_q;
  assign link_data = data_q;
  assign link_k    = k_q;
  assign link_en   = en_q;

  // Checker-only count of enabled words within the current frame (0..2)
  logic [1:0] chk_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_cnt_q <= 2'd0;
    end else if (en_q) begin
      chk_cnt_q <= (chk_cnt_q == 2'd2) ? 2'd0 : chk_cnt_q + 2'd1;
    end
  end

  // R7: payload words are never K-characters
  a_r7_en_not_k: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> !k_q);

  // R4: the second data word of a frame is followed at once by its check word
  a_r4_check_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && chk_cnt_q == 2'd1) |=> en_q);

  // R5: an idle word at a frame boundary is the comma
  a_r5_boundary_comma: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && chk_cnt_q == 2'd0) |-> (k_q && data_q == COMMA));

  // R6: an idle word inside a frame is the padding word
  a_r6_mid_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && chk_cnt_q == 2'd1) |-> (!k_q && data_q == PAD));

endmodule

// File: rtl/lt_link_tx_framer.sv
module lt_link_tx_framer #(
  parameter int                DATA_W     = 16,
  parameter int                DEPTH_LOG2 = 3,
  parameter logic [DATA_W-1:0] COMMA_WORD = 16'h50BC,
  parameter logic [DATA_W-1:0] PAD_WORD   = 16'h0000
) (
  input  logic              sys_clk,
  input  logic              link_clk,
  input  logic              rst_n,
  input  logic              sys_valid,
  input  logic [DATA_W-1:0] sys_data,
  output logic              sys_overflow,
  output logic [DATA_W-1:0] link_data,
  output logic              link_k,
  output logic              link_en
);

  localparam int PW = DEPTH_LOG2 + 1;

  logic                  sys_rst_n;
  logic                  link_rst_n;
  logic                  we;
  logic [DEPTH_LOG2-1:0] waddr;
  logic [DEPTH_LOG2-1:0] raddr;
  logic [DATA_W-1:0]     wdata;
  logic [DATA_W-1:0]     rdata;
  logic [PW-1:0]         wr_gray;
  logic [PW-1:0]         rd_gray;
  logic [PW-1:0]         wr_gray_s;
  logic [PW-1:0]         rd_gray_s;

  lt_rst_sync u_sys_rst  (.clk(sys_clk),  .rst_n_in(rst_n), .rst_n_out(sys_rst_n));
  lt_rst_sync u_link_rst (.clk(link_clk), .rst_n_in(rst_n), .rst_n_out(link_rst_n));

  lt_sync #(.W(PW)) u_rd_to_sys (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  lt_sync #(.W(PW)) u_wr_to_link (
    .clk(link_clk), .rst_n(link_rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  lt_bridge_wr #(.DW(DATA_W), .AW(DEPTH_LOG2)) u_wr (
    .clk      (sys_clk),
    .rst_n    (sys_rst_n),
    .valid    (sys_valid),
    .data     (sys_data),
    .rd_gray_s(rd_gray_s),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .wr_gray  (wr_gray),
    .overflow (sys_overflow)
  );

  lt_dpram #(.DW(DATA_W), .AW(DEPTH_LOG2)) u_buf (
    .wclk (sys_clk),
    .we   (we),
    .waddr(waddr),
    .wdata(wdata),
    .raddr(raddr),
    .rdata(rdata)
  );

  lt_framer #(
    .DW(DATA_W), .AW(DEPTH_LOG2), .COMMA(COMMA_WORD), .PAD(PAD_WORD)
  ) u_fr (
    .clk      (link_clk),
    .rst_n    (link_rst_n),
    .wr_gray_s(wr_gray_s),
    .rdata    (rdata),
    .raddr    (raddr),
    .rd_gray  (rd_gray),
    .link_data(link_data),
    .link_k   (link_k),
    .link_en  (link_en)
  );

endmodule

// File: tb/lt_link_tx_framer_bench.sv
`timescale 1ns/1ps
module lt_link_tx_framer_bench;

  localparam int          DW    = 16;
  localparam int          AW    = 3;
  localparam logic [15:0] COMMA = 16'h50BC;
  localparam logic [15:0] PAD   = 16'h0000;

  logic          sys_clk = 1'b0;
  logic          link_clk = 1'b0;
  logic          link_run = 1'b1;
  logic          rst_n;
  logic          sys_valid;
  logic [DW-1:0] sys_data;
  logic          sys_overflow;
  logic [DW-1:0] link_data;
  logic          link_k;
  logic          link_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] exp_q [$];
  int            out_pos;
  bit            in_pos;
  logic [DW-1:0] first_w;
  bit            cmp_en   = 1'b0;
  bit            model_on = 1'b1;
  int            pad_seen, comma_seen, crc_seen;
  logic [15:0]   lfsr = 16'hACE1;

  lt_link_tx_framer u_lt_link_tx_framer (
    .sys_clk(sys_clk), .link_clk(link_clk), .rst_n(rst_n),
    .sys_valid(sys_valid), .sys_data(sys_data), .sys_overflow(sys_overflow),
    .link_data(link_data), .link_k(link_k), .link_en(link_en)
  );

  always #6.25 sys_clk = ~sys_clk;
  always begin
    #2.5;
    if (link_run) link_clk = ~link_clk;
  end

  function automatic logic [15:0] crc_of(input logic [15:0] seed, input logic [15:0] w);
    logic [15:0] c;
    c = seed;
    for (int i = 15; i >= 0; i--) begin
      if (c[15] ^ w[i]) c = (c << 1) ^ 16'h1021;
      else              c = c << 1;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge sys_clk);
    sys_valid = 1'b1;
    sys_data  = w;
    if (model_on) begin
      exp_q.push_back(w);
      if (!in_pos) begin
        first_w = w;
        in_pos  = 1'b1;
      end else begin
        exp_q.push_back(crc_of(crc_of(16'hFFFF, first_w), w));
        in_pos = 1'b0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sys_clk);
      sys_valid = 1'b0;
    end
  endtask

  // Per-cycle comparison against the behavioural model of the link stream
  always @(negedge link_clk) begin
    if (cmp_en && rst_n) begin
      if (link_en) begin
        check(!link_k, "R7 enabled word K flag", {31'd0, link_k}, 32'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected enabled word", {16'd0, link_data}, 32'd0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(link_data == e, (out_pos == 2) ? "R3 check word" : "R2 data word",
                {16'd0, link_data}, {16'd0, e});
          if (out_pos == 2) crc_seen++;
        end
        out_pos = (out_pos + 1) % 3;
      end else begin
        check(out_pos != 2, "R4 idle before check word", 32'(out_pos), 32'd0);
        if (out_pos == 0) begin
          check(link_k && link_data == COMMA, "R5 boundary comma",
                {15'd0, link_k, link_data}, {16'd1, COMMA});
          comma_seen++;
        end else if (out_pos == 1) begin
          check(!link_k && link_data == PAD, "R6 mid-frame pad",
                {15'd0, link_k, link_data}, {16'd0, PAD});
          pad_seen++;
        end
      end
    end
  end

  initial begin
    #600us;
    if (!done) begin
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    sys_valid = 1'b0;
    sys_data  = '0;
    out_pos   = 0;
    in_pos    = 1'b0;
    #40;
    // R1: reset values
    check(!link_en && link_k && link_data == COMMA, "R1 link outputs in reset",
          {14'd0, link_en, link_k, link_data}, {16'd1, COMMA});
    check(!sys_overflow, "R1 overflow in reset", {31'd0, sys_overflow}, 32'd0);
    @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (6) @(negedge sys_clk);
    check(!link_en && link_k && link_data == COMMA, "R1 link outputs after release",
          {14'd0, link_en, link_k, link_data}, {16'd1, COMMA});
    cmp_en = 1'b1;

    // R2/R3: continuous full-rate stream, incrementing words
    for (int i = 0; i < 120; i++) send(16'(i * 16'h0101 + 3));
    idle(4);
    // R2/R3: gapped stream with pseudo-random data and gaps
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) send(lfsr ^ 16'h5A5A);
      else         idle(1);
    end
    if (in_pos) send(16'hFFFF);
    idle(10);
    // R3 corners: all-zero and all-one words
    send(16'h0000); send(16'h0000);
    send(16'hFFFF); send(16'hFFFF);
    // R6: first word, then a long wait mid-frame
    send(16'h1234);
    idle(12);
    send(16'hABCD);
    idle(40);

    check(exp_q.size() == 0, "R2 all words delivered", 32'(exp_q.size()), 32'd0);
    check(pad_seen > 0, "R6 padding observed", 32'(pad_seen), 32'd1);
    check(comma_seen > 0, "R5 comma observed", 32'(comma_seen), 32'd1);
    check(crc_seen > 0, "R3 check words observed", 32'(crc_seen), 32'd1);
    check(!sys_overflow, "R8 no overflow while link keeps pace",
          {31'd0, sys_overflow}, 32'd0);

    // R8: stall the link clock so that the buffer fills
    cmp_en   = 1'b0;
    model_on = 1'b0;
    @(negedge link_clk);
    link_run = 1'b0;
    for (int i = 0; i < (1 << AW) - 1; i++) send(16'(16'h7700 + i));
    idle(3);
    check(!sys_overflow, "R8 no flag before buffer full", {31'd0, sys_overflow}, 32'd0);
    for (int i = 0; i < 4; i++) send(16'(16'h7800 + i));
    idle(3);
    check(sys_overflow, "R8 flag set on dropped write", {31'd0, sys_overflow}, 32'd1);
    link_run = 1'b1;
    idle(30);
    check(sys_overflow, "R8 flag sticky after drain", {31'd0, sys_overflow}, 32'd1);
    rst_n = 1'b0;
    #20;
    check(!sys_overflow, "R1 reset clears overflow", {31'd0, sys_overflow}, 32'd0);
    check(!link_en && link_k && link_data == COMMA, "R1 link outputs in second reset",
          {14'd0, link_en, link_k, link_data}, {16'd1, COMMA});

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule